// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register file of an interrupt redirection controller. A 32-bit bus reaches it through three offsets. Software writes a register index into a select register, then reads or writes the chosen register through a data window. A third offset accepts end-of-interrupt notifications and passes them onward as a one-cycle strobe that carries the vector.

The register file holds an identification register, a fixed version register and one 64-bit redirection entry per interrupt pin. Each entry is split into two 32-bit halves at consecutive indices. All entries are driven out in parallel to the dispatch logic. The dispatch logic owns the remote-IRR flag of each entry and sets or clears it through per-pin strobes. Software writes cannot alter the remote-IRR flag or the delivery-status flag.

Every bus access is accepted in one cycle. Read data and the access-error flag are registered and appear in the cycle after the access.

Top module: `irq_redir_regwin`

## Requirements
- R1: After reset every redirection entry equals 0x0001_0000_0001_0000, so every pin is masked. The select register, the ID register, bus_rdata, bus_err and eoi_valid are all zero.
- R2: Offset 0x00 is the select register. It stores and returns all 32 written bits. Only bits 7:0 form the index used by the data window.
- R3: Index 0 is the ID register, and a write keeps only data bits 27:24. Index 2 is the arbitration register, and a read of it returns the ID register value.
- R4: Index 1 reads as ((PINS-1) << 16) | 0x11, which is 0x0017_0011 for 24 pins. Writes to index 1 and index 2 change nothing.
- R5: Index 0x10 + 2p is bits 31:0 of the entry for pin p, and index 0x11 + 2p is bits 63:32. Both halves can be read and written through offset 0x10.
- R6: A write to a low half keeps the current values of bit 14 (remote IRR) and bit 12 (delivery status). Every other bit takes the written data.
- R7: An index at or above 0x10 + 2*PINS, or an index from 3 to 0x0F, reads as zero through the window, and a write to it changes no state.
- R8: An access with bus_size other than 2 (where 0 is a byte, 1 a halfword, 2 a word and 3 a doubleword) raises bus_err in the next cycle. It changes no register, and a read of that kind returns zero.
- R9: A read at any offset other than 0x00 or 0x10 returns zero, and this includes the end-of-interrupt offset 0x40. A write at an offset other than 0x00, 0x10 or 0x40 changes nothing.
- R10: A word write to offset 0x40 raises eoi_valid for exactly the next cycle, with eoi_vector equal to data bits 7:0. A read of 0x40 does not raise eoi_valid.
- R11: A pulse on irr_set[p] sets bit 14 of the entry for pin p, and a pulse on irr_clr[p] clears it. When both are asserted in the same cycle, the set wins.
- R12: bus_rdata takes its new value in the cycle after a read access. It holds that value through idle cycles and through write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code, where only 2 (a word) is legal |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Illegal access size seen in the previous cycle |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | Vector that goes with eoi_valid |
| irr_set | input | PINS | Per-pin remote-IRR set strobe |
| irr_clr | input | PINS | Per-pin remote-IRR clear strobe |
| entry_flat | output | PINS*64 | All redirection entries, with pin p at bits 64p+63:64p |

## Verification
The assertions check on every cycle the properties that hold without any scenario. They check that software never moves the remote-IRR or delivery-status bits, and that an illegal access size flags an error and leaves the entries unchanged. They also check that the end-of-interrupt strobe follows only a word write to its offset and carries the low data byte, that the per-pin set and clear strobes take effect with the set winning, and that read data holds except after a read. The index decoding can only be shown by the bench's scenarios: the split between entry halves, the values of the version and arbitration registers, the masking of ID writes, the silence of out-of-range indices, and the use of only the low select bits.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int BUS_W   = 32;
    localparam int ENTRY_W = 64;
    localparam int IDX_W   = 8;
    localparam int VEC_W   = 8;

    // bus offsets
    localparam int OFF_SELECT = 'h00;
    localparam int OFF_WINDOW = 'h10;
    localparam int OFF_EOI    = 'h40;

    // window indices
    localparam int IDX_ID         = 0;
    localparam int IDX_VERSION    = 1;
    localparam int IDX_ARBIT      = 2;
    localparam int IDX_ENTRY_BASE = 'h10;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0001_0000_0001_0000;
    localparam logic [BUS_W-1:0]   ID_KEEP     = 32'h0F00_0000;
    localparam int BIT_REMOTE_IRR = 14;
    localparam int BIT_DLV_STATUS = 12;
    localparam logic [BUS_W-1:0] HW_OWNED =
        (32'd1 << BIT_REMOTE_IRR) | (32'd1 << BIT_DLV_STATUS);

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SELECT,
        ACC_WINDOW,
        ACC_EOI,
        ACC_OTHER,
        ACC_BADSIZE
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t        kind;
        logic             write;
        logic [BUS_W-1:0] data;
    } bus_op_t;

    function automatic logic [BUS_W-1:0] version_word(input int pins);
        logic [BUS_W-1:0] w;
        w = (BUS_W'(pins - 1) << 16) | 32'h11;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] merge_low_half(
        input logic [BUS_W-1:0] cur,
        input logic [BUS_W-1:0] wdata
    );
        return (cur & HW_OWNED) | (wdata & ~HW_OWNED);
    endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [BUS_W-1:0]  bus_wdata,
    output bus_op_t           op
);

    always_comb begin
        op.write = bus_write;
        op.data  = bus_wdata;
        if (!bus_valid) begin
            op.kind = ACC_NONE;
        end else if (bus_size != SIZE_WORD) begin
            op.kind = ACC_BADSIZE;
        end else if (int'(bus_addr) == OFF_SELECT) begin
            op.kind = ACC_SELECT;
        end else if (int'(bus_addr) == OFF_WINDOW) begin
            op.kind = ACC_WINDOW;
        end else if (int'(bus_addr) == OFF_EOI) begin
            op.kind = ACC_EOI;
        end else begin
            op.kind = ACC_OTHER;
        end
    end

endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               irr_set,
    input  logic               irr_clr,
    output logic [ENTRY_W-1:0] entry
);

    logic [ENTRY_W-1:0] entry_nxt;

    always_comb begin
        entry_nxt = entry;
        if (wr_hi) begin
            entry_nxt[ENTRY_W-1:BUS_W] = wdata;
        end
        if (wr_lo) begin
            entry_nxt[BUS_W-1:0] = merge_low_half(entry[BUS_W-1:0], wdata);
        end
        if (irr_set) begin
            entry_nxt[BIT_REMOTE_IRR] = 1'b1;
        end else if (irr_clr) begin
            entry_nxt[BIT_REMOTE_IRR] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry <= ENTRY_RESET;
        end else begin
            entry <= entry_nxt;
        end
    end

endmodule

// File: rtl/irw_readmux.sv
module irw_readmux
    import irw_pkg::*;
#(
    parameter int PINS = 24
) (
    input  logic [IDX_W-1:0]        index,
    input  logic [BUS_W-1:0]        id_reg,
    input  logic [PINS*ENTRY_W-1:0] entries,
    output logic [BUS_W-1:0]        rdata
);

    localparam int IDX_LIMIT = IDX_ENTRY_BASE + 2 * PINS;
    localparam int PIN_W     = IDX_W - 1;

    logic [IDX_W-1:0] rel;
    logic [PIN_W-1:0] pin_sel;
    logic             in_table;

    assign rel      = index - IDX_W'(IDX_ENTRY_BASE);
    assign pin_sel  = rel[IDX_W-1:1];
    assign in_table = (int'(index) >= IDX_ENTRY_BASE) && (int'(index) < IDX_LIMIT);

    always_comb begin
        rdata = '0;
        if (int'(index) == IDX_ID || int'(index) == IDX_ARBIT) begin
            rdata = id_reg;
        end else if (int'(index) == IDX_VERSION) begin
            rdata = version_word(PINS);
        end else if (in_table) begin
            for (int p = 0; p < PINS; p++) begin
                if (int'(pin_sel) == p) begin
                    rdata = rel[0] ? entries[p*ENTRY_W+BUS_W +: BUS_W]
                                   : entries[p*ENTRY_W +: BUS_W];
                end
            end
        end
    end

endmodule

// File: rtl/irq_redir_regwin.sv
module irq_redir_regwin
    import irw_pkg::*;
#(
    parameter int PINS   = 24,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic [BUS_W-1:0]        bus_rdata,
    output logic                    bus_err,
    output logic                    eoi_valid,
    output logic [VEC_W-1:0]        eoi_vector,
    input  logic [PINS-1:0]         irr_set,
    input  logic [PINS-1:0]         irr_clr,
    output logic [PINS*ENTRY_W-1:0] entry_flat
);

    // PINS must lie in 1..120 so that every entry index fits in 8 bits.

    bus_op_t          op;
    logic [BUS_W-1:0] select_q;
    logic [BUS_W-1:0] id_q;
    logic [BUS_W-1:0] win_rdata;
    logic [BUS_W-1:0] rd_value;
    logic [IDX_W-1:0] index;
    logic             win_wr;
    logic [PINS-1:0]  wr_lo;
    logic [PINS-1:0]  wr_hi;

    irw_decode #(.ADDR_W(ADDR_W)) decode_i (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .op        (op)
    );

    assign index  = select_q[IDX_W-1:0];
    assign win_wr = (op.kind == ACC_WINDOW) && op.write;

    // select and identification registers
    always_ff @(posedge clk) begin
        if (rst) begin
            select_q <= '0;
            id_q     <= '0;
        end else begin
            if (op.kind == ACC_SELECT && op.write) begin
                select_q <= op.data;
            end
            if (win_wr && int'(index) == IDX_ID) begin
                id_q <= op.data & ID_KEEP;
            end
        end
    end

    // redirection entries
    for (genvar g = 0; g < PINS; g++) begin : g_pin
        assign wr_lo[g] = win_wr && (int'(index) == IDX_ENTRY_BASE + 2 * g);
        assign wr_hi[g] = win_wr && (int'(index) == IDX_ENTRY_BASE + 2 * g + 1);

        irw_entry entry_i (
            .clk     (clk),
            .rst     (rst),
            .wr_lo   (wr_lo[g]),
            .wr_hi   (wr_hi[g]),
            .wdata   (op.data),
            .irr_set (irr_set[g]),
            .irr_clr (irr_clr[g]),
            .entry   (entry_flat[g*ENTRY_W +: ENTRY_W])
        );
    end

    irw_readmux #(.PINS(PINS)) readmux_i (
        .index   (index),
        .id_reg  (id_q),
        .entries (entry_flat),
        .rdata   (win_rdata)
    );

    always_comb begin
        case (op.kind)
            ACC_SELECT: rd_value = select_q;
            ACC_WINDOW: rd_value = win_rdata;
            default:    rd_value = '0;
        endcase
    end

    // registered bus response and end-of-interrupt strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_err    <= 1'b0;
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            bus_err   <= (op.kind == ACC_BADSIZE);
            eoi_valid <= (op.kind == ACC_EOI) && op.write;
            if (op.kind == ACC_EOI && op.write) begin
                eoi_vector <= op.data[VEC_W-1:0];
            end
            if (op.kind != ACC_NONE && !op.write) begin
                bus_rdata <= rd_value;
            end
        end
    end

endmodule

// File: rtl/irw_checker.sv
module irw_checker
    import irw_pkg::*;
#(
    parameter int PINS   = 24,
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_valid,
    input logic                    bus_write,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [1:0]              bus_size,
    input logic [VEC_W-1:0]        wdata_low,
    input logic [BUS_W-1:0]        bus_rdata,
    input logic                    bus_err,
    input logic                    eoi_valid,
    input logic [VEC_W-1:0]        eoi_vector,
    input logic [PINS-1:0]         irr_set,
    input logic [PINS-1:0]         irr_clr,
    input logic [PINS*ENTRY_W-1:0] entry_flat
);

    logic [2*PINS-1:0] hw_bits;
    logic              bad_size;
    logic              eoi_write;
    logic              hw_quiet;

    assign bad_size  = bus_valid && (bus_size != SIZE_WORD);
    assign eoi_write = bus_valid && bus_write && (bus_size == SIZE_WORD)
                       && (int'(bus_addr) == OFF_EOI);
    assign hw_quiet  = (irr_set == '0) && (irr_clr == '0);

    for (genvar g = 0; g < PINS; g++) begin : g_bits
        assign hw_bits[2*g]   = entry_flat[g*ENTRY_W + BIT_REMOTE_IRR];
        assign hw_bits[2*g+1] = entry_flat[g*ENTRY_W + BIT_DLV_STATUS];

        p_irr_set_r11: assert property (@(posedge clk) disable iff (rst)
            irr_set[g] |=> entry_flat[g*ENTRY_W + BIT_REMOTE_IRR]);

        p_irr_clr_r11: assert property (@(posedge clk) disable iff (rst)
            (irr_clr[g] && !irr_set[g]) |=> !entry_flat[g*ENTRY_W + BIT_REMOTE_IRR]);
    end

    p_hw_bits_kept_r6: assert property (@(posedge clk) disable iff (rst)
        hw_quiet |=> $stable(hw_bits));

    p_bad_size_flag_r8: assert property (@(posedge clk) disable iff (rst)
        bad_size |=> bus_err);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bad_size));

    p_bad_size_no_change_r8: assert property (@(posedge clk) disable iff (rst)
        (bad_size && hw_quiet) |=> $stable(entry_flat));

    p_eoi_cause_r10: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> $past(eoi_write));

    p_eoi_vector_r10: assert property (@(posedge clk) disable iff (rst)
        eoi_write |=> (eoi_valid && eoi_vector == $past(wdata_low)));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid || bus_write) |=> $stable(bus_rdata));

endmodule

bind irq_redir_regwin irw_checker #(.PINS(PINS), .ADDR_W(ADDR_W)) checker_i (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .wdata_low  (bus_wdata[7:0]),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .irr_set    (irr_set),
    .irr_clr    (irr_clr),
    .entry_flat (entry_flat)
);

// File: tb/irq_redir_regwin_tb_top.sv
module irq_redir_regwin_tb_top;

    localparam int PINS = 24;
    localparam logic [63:0] RST_ENT = 64'h0001_0000_0001_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [1:0]        bus_size = 2'd2;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_err;
    logic              eoi_valid;
    logic [7:0]        eoi_vector;
    logic [PINS-1:0]   irr_set = '0;
    logic [PINS-1:0]   irr_clr = '0;
    logic [PINS*64-1:0] entry_flat;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irq_redir_regwin #(.PINS(PINS), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .irr_set(irr_set), .irr_clr(irr_clr),
        .entry_flat(entry_flat)
    );

    function automatic logic [63:0] ent(int p);
        return entry_flat[p*64 +: 64];
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic acc(bit w, logic [7:0] a, logic [31:0] d, logic [1:0] sz);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        bus_size  = sz;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_size  = 2'd2;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        acc(1'b1, a, d, 2'd2);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag, logic [1:0] sz = 2'd2);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        acc(1'b0, a, 32'h0, sz);
    endtask

    task automatic pulse(logic [PINS-1:0] s, logic [PINS-1:0] c);
        @(negedge clk);
        irr_set = s;
        irr_clr = c;
        @(negedge clk);
        irr_set = '0;
        irr_clr = '0;
    endtask

    // monitor: compares registered read data one edge after each read
    initial begin
        forever begin
            bit was_read;
            @(posedge clk);
            was_read = bus_valid && !bus_write && !rst;
            #2;
            if (was_read) begin
                if (exp_q.size() == 0) begin
                    chk("R12 unexpected read", 64'(bus_rdata), 64'hDEAD);
                end else begin
                    chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int p = 0; p < PINS; p++) chk("R1 entry reset", ent(p), RST_ENT);
        chk("R1 err reset", 64'(bus_err), 64'd0);
        chk("R1 eoi reset", 64'(eoi_valid), 64'd0);
        chk("R1 rdata reset", 64'(bus_rdata), 64'd0);
        rd(8'h00, 32'h0, "R1 select reset");
        rd(8'h10, 32'h0, "R1 id reset");

        // R4 version register
        wr(8'h00, 32'h1);
        rd(8'h10, 32'h0017_0011, "R4 version");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0017_0011, "R4 version write ignored");

        // R3 id and arbitration
        wr(8'h00, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0F00_0000, "R3 id masked");
        wr(8'h00, 32'h2);
        rd(8'h10, 32'h0F00_0000, "R3 arbitration mirrors id");
        wr(8'h10, 32'h0);
        wr(8'h00, 32'h0);
        rd(8'h10, 32'h0F00_0000, "R4 arbitration write ignored");

        // R5 and R6 entry halves
        wr(8'h00, 32'h16);
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R6 low write keeps bits 14 12", ent(3), 64'h0001_0000_FFFF_AFFF);
        wr(8'h00, 32'h17);
        wr(8'h10, 32'hAB00_0000);
        chk("R5 high half", ent(3), 64'hAB00_0000_FFFF_AFFF);
        rd(8'h10, 32'hAB00_0000, "R5 read high half");
        chk("R5 neighbour below", ent(2), RST_ENT);
        chk("R5 neighbour above", ent(4), RST_ENT);
        wr(8'h00, 32'h16);
        rd(8'h10, 32'hFFFF_AFFF, "R5 read low half");

        // R12 hold through idle and write cycles
        @(negedge clk);
        chk("R12 hold idle", 64'(bus_rdata), 64'hFFFF_AFFF);
        wr(8'h00, 32'h16);
        chk("R12 hold write", 64'(bus_rdata), 64'hFFFF_AFFF);

        // R2 select width and index bits
        wr(8'h00, 32'h0000_0117);
        rd(8'h00, 32'h0000_0117, "R2 select stores all bits");
        rd(8'h10, 32'hAB00_0000, "R2 index uses low 8 bits");

        // R5 last pin
        wr(8'h00, 32'h3F);
        wr(8'h10, 32'h5500_0000);
        chk("R5 last pin high", ent(23), 64'h5500_0000_0001_0000);
        wr(8'h00, 32'h3E);
        wr(8'h10, 32'h0);
        chk("R5 last pin low", ent(23), 64'h5500_0000_0000_0000);

        // R11 remote IRR from dispatch
        pulse(24'h000008, 24'h0);
        chk("R11 set", ent(3), 64'hAB00_0000_FFFF_EFFF);
        wr(8'h00, 32'h16);
        wr(8'h10, 32'h0);
        chk("R6 irr survives low write", ent(3), 64'hAB00_0000_0000_4000);
        rd(8'h10, 32'h0000_4000, "R6 read irr");
        pulse(24'h0, 24'h000008);
        chk("R11 clear", ent(3), 64'hAB00_0000_0000_0000);
        pulse(24'h000020, 24'h000020);
        chk("R11 set wins", ent(5), 64'h0001_0000_0001_4000);

        // R7 out of range indices
        wr(8'h00, 32'h40);
        rd(8'h10, 32'h0, "R7 read beyond table");
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R7 write beyond table pin23", ent(23), 64'h5500_0000_0000_0000);
        chk("R7 write beyond table pin0", ent(0), RST_ENT);
        wr(8'h00, 32'h05);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0, "R7 gap index");
        wr(8'h00, 32'h00);
        rd(8'h10, 32'h0F00_0000, "R7 gap write left id");

        // R8 illegal sizes
        wr(8'h00, 32'h16);
        acc(1'b1, 8'h10, 32'hFFFF_FFFF, 2'd1);
        chk("R8 err after bad write", 64'(bus_err), 64'd1);
        chk("R8 entry unchanged", ent(3), 64'hAB00_0000_0000_0000);
        acc(1'b1, 8'h00, 32'h99, 2'd0);
        chk("R8 err after bad select write", 64'(bus_err), 64'd1);
        rd(8'h00, 32'h16, "R8 select unchanged");
        chk("R8 err clears", 64'(bus_err), 64'd0);
        rd(8'h10, 32'h0, "R8 bad read returns zero", 2'd3);
        chk("R8 err after bad read", 64'(bus_err), 64'd1);
        acc(1'b1, 8'h40, 32'h55, 2'd1);
        chk("R8 bad eoi no strobe", 64'(eoi_valid), 64'd0);

        // R9 other offsets
        rd(8'h04, 32'h0, "R9 unused offset");
        rd(8'h20, 32'h0, "R9 unused offset 20");
        rd(8'h40, 32'h0, "R9 eoi reads zero");
        chk("R10 read of eoi no strobe", 64'(eoi_valid), 64'd0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h00, 32'h16, "R9 stray write ignored");

        // R10 end of interrupt
        wr(8'h40, 32'h1234_5678);
        chk("R10 eoi strobe", 64'(eoi_valid), 64'd1);
        chk("R10 eoi vector", 64'(eoi_vector), 64'h78);
        @(negedge clk);
        chk("R10 eoi one cycle", 64'(eoi_valid), 64'd0);

        @(negedge clk);
        chk("R12 no pending reads", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule